// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block runs an eight-pin bidirectional port. Each pin has three control bits: a latched output value, a drive-enable bit and a function-select bit. Software sets them through a small register bus. The function bit takes a pin away from its latch. On the two transmit pins, the pin then carries the transmit line of a serial channel. On the other function-capable pins, it releases the pin so a peripheral can use it as an input. The block produces an output value and an output enable for each pin, and the testbench resolves these into tri-state pins.

Pins 0 and 3 carry the transmit lines of serial channels 0 and 1. Each of them has an open-drain select bit. Pins 6 and 7 are always open-drain, and after reset they are set as outputs holding 1, so they float. A mode bit hands pins 6 and 7 to an external low-frequency crystal, and the port then stops driving them. Reads of the data register return the latch for output pins. For input pins they return the pin level after a two-flop synchroniser.

The register map is: address 0 data latch, address 1 direction (1 = output), address 2 function select (pins 0 to 5 only), address 3 mode. In the mode register, bit 0 makes pin 0 open-drain, bit 1 makes pin 3 open-drain and bit 2 enables crystal mode. Writes take effect at the clock edge on which `regWrEn` is high. Reads are combinational on `regAddr`.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the latch reads 0xFF, direction 0xC0, function 0x00 and mode 0x00. `pinOe` is all zero: pins 0 to 5 are inputs, and pins 6 and 7 are outputs holding 1 that float.
- R2: A write to address 1, 2 or 3 is visible on readback after the next clock edge. Function bits 7:6 always read 0, and mode bits 7:3 always read 0.
- R3: For a pin with its function bit clear, its direction bit set and open-drain not in effect, `pinOe` is 1 and `pinOut` equals its latch bit.
- R4: A read of address 0 returns, for each bit, the latch bit where the direction bit is 1 and the synchronised `pinIn` bit where it is 0.
- R5: With its function bit set, pin 0 outputs `serTx0` and pin 3 outputs `serTx1`. Their `pinOe` is 1 whatever the direction and latch bits are, unless open-drain is selected.
- R6: With its function bit set, each of pins 1, 2, 4 and 5 has `pinOe` at 0, whatever its direction bit is.
- R7: When mode bit 0 (pin 0) or mode bit 1 (pin 3) is set, that pin has `pinOut` at 0. Its `pinOe` is 1 only when the pin would drive a 0.
- R8: Pins 6 and 7 are always open-drain: `pinOe` is 1 only when the direction bit is 1 and the latch bit is 0, and `pinOut` is always 0.
- R9: With mode bit 2 set, pins 6 and 7 have `pinOe` at 0 whatever the latch and direction bits are.
- R10: A change on `pinIn` reaches the address-0 read only after two rising clock edges. After one edge the previous level is still returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for write and read |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| serTx0 | input | 1 | Transmit line of serial channel 0 |
| serTx1 | input | 1 | Transmit line of serial channel 1 |
| pinIn | input | 8 | Pin levels seen from the pads |
| pinOut | output | 8 | Per-pin output value |
| pinOe | output | 8 | Per-pin output enable |

## Verification
Register writes change `pinOut`, `pinOe` and the readback one clock edge after the write strobe. The bench drives each write at a falling edge and samples at the next falling edge, after the rising edge that commits it. Changes on `serTx0` and `serTx1` reach the pins with no clock, so the bench samples them a short delay after driving them. A `pinIn` change needs two rising edges before it shows on the data read. The bench samples once after the first edge to confirm the old level, then again after the second edge. The sweep covers every mode value, every transmit pair and sixteen register patterns, and it checks each pin against an arithmetic model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_FUNC = 2'd2,
    REG_MODE = 2'd3
  } regSel_e;

  localparam int MODE_W    = 3;
  localparam int MODE_OD0  = 0;
  localparam int MODE_OD1  = 1;
  localparam int MODE_XTAL = 2;

  typedef struct packed {
    logic    latchWe;
    logic    dirWe;
    logic    funcWe;
    logic    modeWe;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[s] <= '0;
        end else begin
          if (s == 0) stageQ[s] <= asyncIn;
          else        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  output ctrlStrobe_t strobe
);

  regSel_e sel;

  always_comb begin
    sel            = regSel_e'(regAddr);
    strobe         = '0;
    strobe.rdSel   = sel;
    strobe.latchWe = regWrEn && (sel == REG_DATA);
    strobe.dirWe   = regWrEn && (sel == REG_DIR);
    strobe.funcWe  = regWrEn && (sel == REG_FUNC);
    strobe.modeWe  = regWrEn && (sel == REG_MODE);
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int               PIN_W         = 8,
  parameter int               SYNC_STAGES   = 2,
  parameter int               TX0_PIN       = 0,
  parameter int               TX1_PIN       = 3,
  parameter logic [PIN_W-1:0] FUNC_MASK     = 8'h3F,
  parameter logic [PIN_W-1:0] FIXED_OD_MASK = 8'hC0,
  parameter logic [PIN_W-1:0] XTAL_MASK     = 8'hC0,
  parameter logic [PIN_W-1:0] DIR_RESET     = 8'hC0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [PIN_W-1:0] wrData,
  output logic [PIN_W-1:0] rdData,
  input  logic             serTx0,
  input  logic             serTx1,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe
);

  logic [PIN_W-1:0]  latchQ;
  logic [PIN_W-1:0]  dirQ;
  logic [PIN_W-1:0]  funcQ;
  logic [MODE_W-1:0] modeQ;
  logic [PIN_W-1:0]  syncIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '1;
      dirQ   <= DIR_RESET;
      funcQ  <= '0;
      modeQ  <= '0;
    end else begin
      if (strobe.latchWe) latchQ <= wrData;
      if (strobe.dirWe)   dirQ   <= wrData;
      if (strobe.funcWe)  funcQ  <= wrData & FUNC_MASK;
      if (strobe.modeWe)  modeQ  <= wrData[MODE_W-1:0];
    end
  end

  gpio_port_sync #(
    .WIDTH (PIN_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinIn),
    .syncOut(syncIn)
  );

  genvar i;
  generate
    for (i = 0; i < PIN_W; i++) begin : g_pin
      localparam bit IS_TX0   = (i == TX0_PIN);
      localparam bit IS_TX1   = (i == TX1_PIN);
      localparam bit IS_TX    = IS_TX0 || IS_TX1;
      localparam bit FIXED_OD = FIXED_OD_MASK[i];
      localparam bit IS_XTAL  = XTAL_MASK[i];

      logic txSrc;
      logic odSel;
      logic srcVal;
      logic driveReq;
      logic odOn;
      logic xtalOn;

      if (IS_TX0) begin : g_tx0
        assign txSrc = serTx0;
        assign odSel = modeQ[MODE_OD0];
      end else if (IS_TX1) begin : g_tx1
        assign txSrc = serTx1;
        assign odSel = modeQ[MODE_OD1];
      end else begin : g_plain
        assign txSrc = 1'b0;
        assign odSel = 1'b0;
      end

      always_comb begin
        srcVal   = (funcQ[i] && IS_TX) ? txSrc : latchQ[i];
        driveReq = funcQ[i] ? IS_TX : dirQ[i];
        odOn     = FIXED_OD || odSel;
        xtalOn   = IS_XTAL && modeQ[MODE_XTAL];
        pinOe[i]  = !xtalOn && driveReq && (!odOn || !srcVal);
        pinOut[i] = !xtalOn && !odOn && srcVal;
      end
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      REG_DATA: rdData = (dirQ & latchQ) | (~dirQ & syncIn);
      REG_DIR:  rdData = dirQ;
      REG_FUNC: rdData = funcQ;
      REG_MODE: rdData = {{(PIN_W-MODE_W){1'b0}}, modeQ};
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [PIN_W-1:0] regWrData,
  output logic [PIN_W-1:0] regRdData,
  input  logic             serTx0,
  input  logic             serTx1,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe
);

  ctrlStrobe_t strobe;

  gpio_port_ctrl u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  gpio_port_datapath #(
    .PIN_W      (PIN_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_data (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(regWrData),
    .rdData(regRdData),
    .serTx0(serTx0),
    .serTx1(serTx1),
    .pinIn (pinIn),
    .pinOut(pinOut),
    .pinOe (pinOe)
  );

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int PIN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic [PIN_W-1:0] regWrData,
  input logic [PIN_W-1:0] regRdData,
  input logic [PIN_W-1:0] pinOut,
  input logic [PIN_W-1:0] pinOe
);

  AST_RESET_FLOAT: assert property (@(posedge clk)
    !rstN |=> pinOe == '0); // R1

  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1) |=> (regAddr != 2'd1 || regRdData == $past(regWrData))); // R2

  AST_OD_PIN0_LOW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && regWrData[0]) |=> !pinOut[0]); // R7

  AST_OD_FIXED_PINS: assert property (@(posedge clk) disable iff (!rstN)
    !pinOut[6] && !pinOut[7]); // R8

  AST_XTAL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && regWrData[2]) |=> (pinOe[7:6] == 2'b00)); // R9

endmodule

bind gpio_mux_port gpio_mux_port_chk #(.PIN_W(PIN_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .pinOut   (pinOut),
  .pinOe    (pinOe)
);

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       serTx0 = 1'b0;
  logic       serTx1 = 1'b0;
  logic [7:0] pinIn = 8'h00;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .serTx0(serTx0),
    .serTx1(serTx1), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] addr, output logic [7:0] data);
    regAddr = addr;
    #1;
    data = regRdData;
  endtask

  // Expected {oe, out} for one pin, from the requirements
  function automatic logic [1:0] expPin(input int i, input logic l, input logic d, input logic f,
                                        input logic [2:0] m, input logic t0, input logic t1);
    logic isTx, src, drv, od, xt, oe, o;
    isTx = (i == 0) || (i == 3);
    src  = (f && i == 0) ? t0 : (f && i == 3) ? t1 : l;
    drv  = f ? isTx : d;
    od   = (i >= 6) || (i == 0 && m[0]) || (i == 3 && m[1]);
    xt   = (i >= 6) && m[2];
    oe   = !xt && drv && (!od || !src);
    o    = !xt && !od && src;
    return {oe, o};
  endfunction

  function automatic string reqOf(input int i, input logic d, input logic f, input logic [2:0] m);
    if (i >= 6 && m[2]) return "R9";
    if (i >= 6) return "R8";
    if ((i == 0 && m[0]) || (i == 3 && m[1])) return "R7";
    if (f && (i == 0 || i == 3)) return "R5";
    if (f) return "R6";
    if (d) return "R3";
    return "R3";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    pinIn = 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    check("R1", "pinOe", pinOe, 8'h00);
    regRead(2'd1, rd); check("R1", "dir", rd, 8'hC0);
    regRead(2'd2, rd); check("R1", "func", rd, 8'h00);
    regRead(2'd3, rd); check("R1", "mode", rd, 8'h00);
    regRead(2'd0, rd); check("R1", "data", rd, 8'hDA);

    // R2: unimplemented bits read zero
    regWrite(2'd2, 8'hFF); regRead(2'd2, rd); check("R2", "func mask", rd, 8'h3F);
    regWrite(2'd3, 8'hFF); regRead(2'd3, rd); check("R2", "mode mask", rd, 8'h07);
    regWrite(2'd2, 8'h00); regWrite(2'd3, 8'h00);

    // R10: two-edge synchroniser latency
    regWrite(2'd1, 8'h00);
    @(negedge clk); pinIn = 8'hA5;
    regRead(2'd0, rd);
    @(negedge clk); regRead(2'd0, rd); check("R10", "after 1 edge", rd, 8'h5A);
    @(negedge clk); regRead(2'd0, rd); check("R10", "after 2 edges", rd, 8'hA5);

    // Sweep: 16 register patterns x 8 modes x 4 transmit pairs
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 8; m++) begin
        logic [7:0] lat, dir, fun, pin;
        lat = 8'((p * 37 + m * 11 + 5) & 8'hFF);
        dir = 8'((p * 91 + 3) & 8'hFF);
        fun = 8'((p * 53 + m) & 8'h3F);
        pin = 8'(~lat ^ (p * 7));
        pinIn = pin;
        regWrite(2'd0, lat);
        regWrite(2'd1, dir);
        regWrite(2'd2, fun);
        regWrite(2'd3, 8'(m));
        @(negedge clk);
        regRead(2'd1, rd); check("R2", "dir readback", rd, dir);
        regRead(2'd2, rd); check("R2", "func readback", rd, fun);
        regRead(2'd3, rd); check("R2", "mode readback", rd, 8'(m));
        regRead(2'd0, rd); check("R4", "data read", rd, (dir & lat) | (~dir & pin));
        for (int t = 0; t < 4; t++) begin
          serTx0 = t[0]; serTx1 = t[1];
          #1;
          for (int i = 0; i < 8; i++) begin
            logic [1:0] e;
            e = expPin(i, lat[i], dir[i], fun[i], 3'(m), t[0], t[1]);
            check(reqOf(i, dir[i], fun[i], 3'(m)), $sformatf("pin%0d oe", i), 32'(pinOe[i]), 32'(e[1]));
            if (e[1])
              check(reqOf(i, dir[i], fun[i], 3'(m)), $sformatf("pin%0d out", i), 32'(pinOut[i]), 32'(e[0]));
          end
        end
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule